// File: doc/BRIEF.md
# Terminal-side line activation controller

This block sequences the activation handshake of a terminal on a four-wire basic-rate S/T loop. It takes a decoded class of the received line signal, a frame-alignment flag and frame strobes from the line receiver. It decides which signal class the transmitter sends: silence (INFO0), the wake-up signal (INFO1) or the active terminal signal (INFO3). Line coding, timing recovery and the bearer and signalling channels are handled elsewhere.

The host starts an activation with a one-cycle write strobe. This sets a request bit that clears itself once the state machine has taken up the request. The terminal sends the wake-up signal until any far-end signal appears, then goes silent while it aligns. It answers with INFO3 once INFO2 has been seen, aligned, for a run of consecutive frames. A terminal that receives aligned INFO4 joins the loop at once, with no handshake. A test bit forces INFO3 onto the line whatever the handshake state. Three status bits report frame alignment, full activation and an error condition.

Top module: `te_act_ctrl`

## Requirements
- R1: Signal classes use a 3-bit code: 0 = INFO0, 1 = INFO1, 2 = INFO2, 3 = INFO3, 4 = INFO4, 5 = unidentified far-end signal, 7 = no signal. A far-end signal is present when the receive code is 2, 4 or 5. The transmit code only ever takes the values 0, 1 or 3. After reset it is 0 and every status bit is 0.
- R2: A request strobe while the loop is inactive sets `req_pending` at the next clock edge. At the edge after that, `tx_class` becomes 1 (INFO1) and `req_pending` returns to 0.
- R3: A request strobe while the controller is not inactive has no effect: `req_pending` stays 0.
- R4: While INFO1 is being sent, a far-end signal present at a clock edge makes `tx_class` 0 (INFO0) after that edge.
- R5: INFO2 counts as verified after VERIFY_FRAMES (default 3) frame strobes that each see receive code 2 with `rx_aligned` high. Any cycle without code 2 and alignment restarts the count. The edge after verification makes `tx_class` 3.
- R6: Receive code 4 with `rx_aligned` high at a clock edge, from the inactive or aligning state, makes `tx_class` 3 after that edge, with no INFO1 sent.
- R7: While `force_info3` is 1, `tx_class` is 3 in the same cycle. Clearing it restores the handshake's own code.
- R8: `st_aligned` is 1 exactly when `rx_aligned` is high and the receive code is 2 or 4.
- R9: `st_active` is 1 exactly when `tx_class` is 3 and the receive code is 4.
- R10: Loss of alignment while fully active sets `st_error` and returns the transmitter to INFO0 after that edge. Aligned INFO4 returning clears `st_error` and restores INFO3 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_class | input | 3 | Decoded receive signal class |
| rx_aligned | input | 1 | Receiver has frame alignment |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| req_wr | input | 1 | Host write of 1 to the activation request bit |
| force_info3 | input | 1 | Test bit forcing INFO3 transmission |
| tx_class | output | 3 | Transmit signal class |
| req_pending | output | 1 | Self-clearing activation request bit |
| st_aligned | output | 1 | Frame alignment status |
| st_active | output | 1 | Fully active status |
| st_error | output | 1 | Error indication status |

## Verification
A state machine stuck in the wrong state shows at `tx_class` one edge after the stimulus that should have moved it. This is visible as INFO1 lingering after a far-end signal, or as INFO3 appearing without verification. A wrong INFO2 run counter moves the INFO3 onset by whole frame strobes, so the bench checks the edge just before and the edge just after the expected onset. A wrong error flag shows at `st_error` within one cycle of losing or regaining alignment.

// File: rtl/te_act_pkg.sv
// Package: shared signal-class codes and controller states.
// Assumes the line receiver already maps the line signal onto these codes.
package te_act_pkg;
    typedef enum logic [2:0] {
        SIG_INFO0 = 3'd0,
        SIG_INFO1 = 3'd1,
        SIG_INFO2 = 3'd2,
        SIG_INFO3 = 3'd3,
        SIG_INFO4 = 3'd4,
        SIG_ANY   = 3'd5,
        SIG_NONE  = 3'd7
    } sig_class_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAKE    = 3'd1,
        ST_ALIGN   = 3'd2,
        ST_ANSWER  = 3'd3,
        ST_RUNNING = 3'd4
    } act_state_t;

    function automatic logic far_end_present(input logic [2:0] c);
        return (c == SIG_INFO2) || (c == SIG_INFO4) || (c == SIG_ANY);
    endfunction
endpackage

// File: rtl/te_info2_verify.sv
// Module: counts consecutive frame strobes that see aligned INFO2.
// Assumes frame_stb is a one-cycle pulse. Any cycle without aligned INFO2
// restarts the run. The count saturates at RUN_LEN.
module te_info2_verify #(
    parameter int RUN_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rx_class,
    input  logic       rx_aligned,
    input  logic       frame_stb,
    output logic       verified
);
    import te_act_pkg::*;

    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;
    logic          good;

    assign good = rx_aligned && (rx_class == SIG_INFO2);

    // Run counter: restart on a bad cycle, advance on a good strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !good)
            run_cnt <= '0;
        else if (frame_stb && (run_cnt != CW'(RUN_LEN)))
            run_cnt <= run_cnt + 1'b1;
    end

    assign verified = good && (run_cnt == CW'(RUN_LEN));
endmodule

// File: rtl/te_act_fsm.sv
// Module: handshake state machine and self-clearing request bit.
// Assumes the inputs are synchronous to clk. The request bit is taken up
// only in the idle state, and clears on any exit from idle.
module te_act_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             rx_class,
    input  logic                   rx_aligned,
    input  logic                   info2_ok,
    input  logic                   req_wr,
    output te_act_pkg::act_state_t state,
    output logic                   req_pending,
    output logic                   err_flag
);
    import te_act_pkg::*;

    act_state_t nxt;
    logic       info4_ok;

    assign info4_ok = rx_aligned && (rx_class == SIG_INFO4);

    // Next-state decision from the current state and receive conditions.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (info4_ok)                       nxt = ST_RUNNING;
                else if (far_end_present(rx_class)) nxt = ST_ALIGN;
                else if (req_pending)               nxt = ST_WAKE;
            end
            ST_WAKE:    if (far_end_present(rx_class)) nxt = ST_ALIGN;
            ST_ALIGN: begin
                if (info4_ok)      nxt = ST_RUNNING;
                else if (info2_ok) nxt = ST_ANSWER;
            end
            ST_ANSWER: begin
                if (info4_ok)        nxt = ST_RUNNING;
                else if (!rx_aligned) nxt = ST_ALIGN;
            end
            ST_RUNNING: begin
                if (!rx_aligned)                nxt = ST_ALIGN;
                else if (rx_class != SIG_INFO4) nxt = ST_ANSWER;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request bit: set by a host write while idle, cleared on leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_pending <= 1'b0;
        else if (state == ST_IDLE && nxt != ST_IDLE)
            req_pending <= 1'b0;
        else if (state == ST_IDLE && req_wr)
            req_pending <= 1'b1;
        else if (state != ST_IDLE)
            req_pending <= 1'b0;
    end

    // Error flag: raised on alignment loss while running, cleared on return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (state == ST_RUNNING && !rx_aligned)
            err_flag <= 1'b1;
        else if (nxt == ST_RUNNING)
            err_flag <= 1'b0;
    end
endmodule

// File: rtl/te_act_ctrl.sv
// Module: top of the terminal activation controller. It drives the transmit
// class from the state machine, applies the force bit and builds the status
// bits. Assumes rx_class, rx_aligned and frame_stb are synchronous to clk.
module te_act_ctrl #(
    parameter int VERIFY_FRAMES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rx_class,
    input  logic       rx_aligned,
    input  logic       frame_stb,
    input  logic       req_wr,
    input  logic       force_info3,
    output logic [2:0] tx_class,
    output logic       req_pending,
    output logic       st_aligned,
    output logic       st_active,
    output logic       st_error
);
    import te_act_pkg::*;

    act_state_t state;
    logic       info2_ok;
    logic [2:0] hs_tx;

    te_info2_verify #(.RUN_LEN(VERIFY_FRAMES)) u_verify (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_class   (rx_class),
        .rx_aligned (rx_aligned),
        .frame_stb  (frame_stb),
        .verified   (info2_ok)
    );

    te_act_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_class    (rx_class),
        .rx_aligned  (rx_aligned),
        .info2_ok    (info2_ok),
        .req_wr      (req_wr),
        .state       (state),
        .req_pending (req_pending),
        .err_flag    (st_error)
    );

    // Handshake transmit class from the current state.
    always_comb begin
        unique case (state)
            ST_WAKE:               hs_tx = SIG_INFO1;
            ST_ANSWER, ST_RUNNING: hs_tx = SIG_INFO3;
            default:               hs_tx = SIG_INFO0;
        endcase
    end

    // Force bit overrides the handshake.
    assign tx_class = force_info3 ? 3'(SIG_INFO3) : hs_tx;

    // Status bits from the receive and transmit classes.
    assign st_aligned = rx_aligned && (rx_class == SIG_INFO2 || rx_class == SIG_INFO4);
    assign st_active  = (tx_class == SIG_INFO3) && (rx_class == SIG_INFO4);
endmodule

// File: rtl/te_act_ctrl_chk.sv
// Checker: port-level properties of te_act_ctrl, bound to every instance.
module te_act_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rx_class,
    input logic       rx_aligned,
    input logic       force_info3,
    input logic [2:0] tx_class,
    input logic       req_pending,
    input logic       st_aligned,
    input logic       st_error
);
    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_tx_codes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_class == 3'd0 || tx_class == 3'd1 || tx_class == 3'd3);

    a_r2_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_class == 3'd1) |-> !req_pending);

    a_r4_wake_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_class == 3'd1 && (rx_class == 3'd2 || rx_class == 3'd4 || rx_class == 3'd5))
        |=> (tx_class != 3'd1));

    a_r5_info3_after_align: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tx_class == 3'd3 && !force_info3 && $past(tx_class != 3'd3))
        |-> $past(st_aligned));

    a_r10_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(st_error)) |-> ($past(tx_class == 3'd3) && !$past(rx_aligned)));

    a_r10_err_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(st_error)) |-> $past(rx_class == 3'd4 && rx_aligned));
endmodule

bind te_act_ctrl te_act_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_class    (rx_class),
    .rx_aligned  (rx_aligned),
    .force_info3 (force_info3),
    .tx_class    (tx_class),
    .req_pending (req_pending),
    .st_aligned  (st_aligned),
    .st_error    (st_error)
);

// File: tb/te_act_ctrl_test.sv
// Directed bench: one task per scenario. Inputs change on the falling edge,
// and outputs are sampled on the falling edge after each rising edge.
module te_act_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] rx_class;
    logic       rx_aligned;
    logic       frame_stb;
    logic       req_wr;
    logic       force_info3;
    logic [2:0] tx_class;
    logic       req_pending, st_aligned, st_active, st_error;

    int checks = 0;
    int errors = 0;

    te_act_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_class(rx_class), .rx_aligned(rx_aligned),
        .frame_stb(frame_stb), .req_wr(req_wr), .force_info3(force_info3),
        .tx_class(tx_class), .req_pending(req_pending), .st_aligned(st_aligned),
        .st_active(st_active), .st_error(st_error)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_class = 3'd7; rx_aligned = 1'b0; frame_stb = 1'b0;
        req_wr = 1'b0; force_info3 = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // Emits one frame strobe followed by three quiet cycles.
    task automatic frame();
        frame_stb = 1'b1; step(); frame_stb = 1'b0;
        step(); step(); step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx after reset", tx_class, 0);
        chk("R1 req after reset", req_pending, 0);
        chk("R1 status after reset", {st_aligned, st_active, st_error}, 0);
    endtask

    task automatic t_request();
        do_reset();
        req_wr = 1'b1; step(); req_wr = 1'b0;
        chk("R2 req set", req_pending, 1);
        chk("R2 still silent", tx_class, 0);
        step();
        chk("R2 wake sent", tx_class, 1);
        chk("R2 req self-cleared", req_pending, 0);
        rx_class = 3'd5; step();
        chk("R4 wake stops on far-end signal", tx_class, 0);
    endtask

    task automatic t_verify();
        do_reset();
        req_wr = 1'b1; step(); req_wr = 1'b0; step();
        rx_class = 3'd2; rx_aligned = 1'b1; #1;
        chk("R8 aligned INFO2", st_aligned, 1);
        step();
        chk("R4 silent while aligning", tx_class, 0);
        frame(); frame();
        rx_aligned = 1'b0; #1;
        chk("R8 not aligned", st_aligned, 0);
        step(); rx_aligned = 1'b1;
        frame(); frame();
        chk("R5 run restarted, no INFO3", tx_class, 0);
        frame_stb = 1'b1; step(); frame_stb = 1'b0;
        chk("R5 third strobe edge, not yet", tx_class, 0);
        step();
        chk("R5 INFO3 after verify", tx_class, 3);
        chk("R9 not active on INFO2", st_active, 0);
        rx_class = 3'd4; #1;
        chk("R9 active on INFO3+INFO4", st_active, 1);
        step();
        chk("R9 still active", st_active, 1);
        rx_aligned = 1'b0; step();
        chk("R10 error raised", st_error, 1);
        chk("R10 back to silence", tx_class, 0);
        rx_aligned = 1'b1; step();
        chk("R10 error cleared", st_error, 0);
        chk("R10 INFO3 restored", tx_class, 3);
    endtask

    task automatic t_direct();
        do_reset();
        rx_class = 3'd4; rx_aligned = 1'b1; #1;
        chk("R8 aligned INFO4", st_aligned, 1);
        step();
        chk("R6 direct INFO3", tx_class, 3);
        chk("R6 active", st_active, 1);
        req_wr = 1'b1; step(); req_wr = 1'b0;
        chk("R3 request ignored when active", req_pending, 0);
        step();
        chk("R3 request did not disturb tx", tx_class, 3);
    endtask

    task automatic t_force();
        do_reset();
        force_info3 = 1'b1; #1;
        chk("R7 forced INFO3", tx_class, 3);
        step();
        chk("R7 forced INFO3 held", tx_class, 3);
        force_info3 = 1'b0; #1;
        chk("R7 release to handshake", tx_class, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_request();
                t_verify();
                t_direct();
                t_force();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule